// File: doc/BRIEF.md
# Byte-Parallel CRC Update Unit

This block keeps a running cyclic redundancy check over a byte stream and absorbs one data byte in each clock cycle where the byte strobe is high. It needs no lookup table. Each supported polynomial has its own hand-reduced set of shift and XOR equations that turns the current register and the incoming byte into the next register value in a single combinational step. Two of these equation sets use a parity term over the byte.

A parameter fixes the polynomial and its bit order when the block is built, and a second parameter gives the preset value. The host pulses the restart input at the start of a message, streams the bytes in, and reads the register at the output. The block can also check a received message in one pass: the host feeds the message followed by its CRC, and a correct frame leaves a known residue in the register.

Top module: `crcb_unit`

## Requirements
- R1: While reset is active, and after its release until the first update, the register holds the preset value cut down to the register width.
- R2: A high `init_i` at a clock edge loads the preset value and takes priority over `byte_vld_i` in the same cycle.
- R3: With `init_i` and `byte_vld_i` both low, the register keeps its value.
- R4: VARIANT 0 is an 8-bit register with divisor 0x12 (x^7+x^3+1 shifted left by one). It is MSB-first, so data bit 7 enters first. After any update, bit 0 of the register is 0.
- R5: VARIANT 1 is an 8-bit register with divisor 0x8C. It is reflected, so data bit 0 enters first and the register shifts toward bit 0.
- R6: VARIANT 2 is a 16-bit register with divisor 0x1021. It is MSB-first, so data bit 7 enters first at register bit 15.
- R7: VARIANT 3 is a 16-bit register with divisor 0xA001. It is reflected, so data bit 0 enters first.
- R8: VARIANT 4 is a 16-bit register with divisor 0x8005. It is MSB-first.
- R9: For the 8-bit variants, bits 15:8 of `crc_o` always read 0.
- R10: Take a message and append its CRC, high byte first for an MSB-first variant. Feeding the result through the unit, starting from any preset, leaves 0 in the register.
- R11: For every variant, each byte update equals eight single-bit divisor steps taken in that variant's bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Reload the register with the preset |
| byte_vld_i | input | 1 | Absorb `byte_i` at this edge |
| byte_i | input | 8 | Data byte |
| crc_o | output | 16 | Current register, zero-extended for 8-bit variants |

## Verification
The assertions assume that `init_i`, `byte_vld_i` and `byte_i` carry known values at every sampled edge once reset has been released. They also assume that reset is only released after the register has taken its preset. The stimulus keeps to this by driving every input at the falling clock edge from fixed starting values, and by holding reset for several cycles before letting it go. The zero-feedback property holds only when the incoming byte cancels the register's leading byte. The random streams produce that case only now and then, so the directed one-pass check feeds such bytes on purpose.

// File: rtl/crcb_pkg.sv
package crcb_pkg;

    typedef enum logic [2:0] {
        CRCB_SH7_MSB   = 3'd0,
        CRCB_8C_REFL   = 3'd1,
        CRCB_1021_MSB  = 3'd2,
        CRCB_A001_REFL = 3'd3,
        CRCB_8005_MSB  = 3'd4
    } crcb_variant_e;

    function automatic int unsigned crcb_width(input int unsigned variant);
        return (variant < 2) ? 8 : 16;
    endfunction

    function automatic bit crcb_reflected(input int unsigned variant);
        return (variant == 1) || (variant == 3);
    endfunction

endpackage

// File: rtl/crcb_parity.sv
module crcb_parity #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] vec_i,
    output logic         par_o
);
    logic [W:0] acc_w;

    assign acc_w[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_chain
        assign acc_w[i+1] = acc_w[i] ^ vec_i[i];
    end
    assign par_o = acc_w[W];
endmodule

// File: rtl/crcb_step.sv
module crcb_step
    import crcb_pkg::*;
#(
    parameter int unsigned VARIANT = 2,
    parameter int unsigned W       = crcb_width(VARIANT)
) (
    input  logic [W-1:0] crc_i,
    input  logic [7:0]   dat_i,
    output logic [W-1:0] crc_o
);
    if (VARIANT == 0) begin : g_sh7
        logic [7:0] e_w, f_w;
        assign e_w   = crc_i ^ dat_i;
        assign f_w   = e_w ^ (e_w >> 4) ^ (e_w >> 7);
        assign crc_o = (f_w << 1) ^ (f_w << 4);
    end else if (VARIANT == 1) begin : g_r8c
        logic [7:0] e_w, f_w;
        assign e_w   = crc_i ^ dat_i;
        assign f_w   = e_w ^ (e_w << 3) ^ (e_w << 4) ^ (e_w << 6);
        assign crc_o = f_w ^ (f_w >> 4) ^ (f_w >> 5);
    end else if (VARIANT == 2) begin : g_m1021
        logic [7:0]  s_w, t_w;
        logic [15:0] t16_w;
        assign s_w   = dat_i ^ crc_i[15:8];
        assign t_w   = s_w ^ (s_w >> 4);
        assign t16_w = {8'h00, t_w};
        assign crc_o = (crc_i << 8) ^ t16_w ^ (t16_w << 5) ^ (t16_w << 12);
    end else if (VARIANT == 3) begin : g_ra001
        logic [7:0]  e_w;
        logic        p_w;
        logic [15:0] f16_w;
        assign e_w = crc_i[7:0] ^ dat_i;
        crcb_parity #(.W(8)) u_par (.vec_i(e_w), .par_o(p_w));
        assign f16_w = {7'd0, p_w, e_w};
        assign crc_o = (crc_i >> 8) ^ (f16_w << 6) ^ (f16_w << 7) ^ (f16_w >> 8);
    end else begin : g_m8005
        logic [7:0]  s_w;
        logic        p_w;
        logic [15:0] t16_w;
        assign s_w = dat_i ^ crc_i[15:8];
        crcb_parity #(.W(8)) u_par (.vec_i(s_w), .par_o(p_w));
        assign t16_w = {7'd0, s_w, p_w};
        assign crc_o = (crc_i << 8) ^ (t16_w << 15) ^ t16_w ^ (t16_w << 1);
    end
endmodule

// File: rtl/crcb_unit.sv
module crcb_unit
    import crcb_pkg::*;
#(
    parameter int unsigned VARIANT = 2,
    parameter logic [15:0] PRESET  = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_i,
    input  logic        byte_vld_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);
    localparam int unsigned CRC_W    = crcb_width(VARIANT);
    localparam bit          REFLECT  = crcb_reflected(VARIANT);
    localparam logic [CRC_W-1:0] PRESET_M = PRESET[CRC_W-1:0];

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } state_t;

    state_t           st_d, st_q;
    logic [CRC_W-1:0] step_w;
    logic [7:0]       fb_byte_w;

    crcb_step #(.VARIANT(VARIANT), .W(CRC_W)) u_step (
        .crc_i (st_q.crc),
        .dat_i (byte_i),
        .crc_o (step_w)
    );

    always_comb begin
        st_d = st_q;
        if (init_i) begin
            st_d.crc = PRESET_M;
        end else if (byte_vld_i) begin
            st_d.crc = step_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{crc: PRESET_M};
        end else begin
            st_q <= st_d;
        end
    end

    if (CRC_W == 16) begin : g_out16
        assign crc_o = st_q.crc;
    end else begin : g_out8
        assign crc_o = {8'h00, st_q.crc};
    end

    if (REFLECT) begin : g_fb_refl
        assign fb_byte_w = st_q.crc[7:0];
    end else begin : g_fb_msb
        assign fb_byte_w = st_q.crc[CRC_W-1 -: 8];
    end

    // R2
    init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (st_q.crc == PRESET_M));

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !byte_vld_i) |=> $stable(crc_o));

    // R11
    zero_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !init_i && (byte_i == fb_byte_w)) |=>
        (st_q.crc == (REFLECT ? ($past(st_q.crc) >> 8) : ($past(st_q.crc) << 8))));

    if (VARIANT == 0) begin : g_sh7_chk
        // R4
        sh7_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (byte_vld_i && !init_i) |=> (crc_o[0] == 1'b0));
    end
endmodule

// File: tb/crcb_unit_test.sv
module crcb_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;

    localparam logic [7:0] MSG [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35,
                                       8'h36, 8'h37, 8'h38, 8'h39};
    localparam logic [15:0] CHECK [NV] = '{16'h00EA, 16'h00A1, 16'h29B1,
                                           16'hBB3D, 16'hFEE8};
    localparam logic [15:0] PRE [NV] = '{16'h0000, 16'h0000, 16'hFFFF,
                                         16'h0000, 16'h0000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        init_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic [15:0] out_v [NV];
    logic [15:0] mdl [NV];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crcb_unit #(.VARIANT(0), .PRESET(16'h0000)) u_sh7 (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .crc_o(out_v[0]));
    crcb_unit #(.VARIANT(1), .PRESET(16'h0000)) u_r8c (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .crc_o(out_v[1]));
    crcb_unit #(.VARIANT(2), .PRESET(16'hFFFF)) uut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .crc_o(out_v[2]));
    crcb_unit #(.VARIANT(3), .PRESET(16'h0000)) u_ra001 (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .crc_o(out_v[3]));
    crcb_unit #(.VARIANT(4), .PRESET(16'h0000)) u_m8005 (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .crc_o(out_v[4]));

    function automatic logic [15:0] serial_step(input int v, input logic [15:0] c_in,
                                                input logic [7:0] d);
        logic [15:0] c = c_in;
        logic [15:0] poly;
        int          w;
        bit          refl;
        logic        fb;
        case (v)
            0: begin poly = 16'h0012; w = 8;  refl = 1'b0; end
            1: begin poly = 16'h008C; w = 8;  refl = 1'b1; end
            2: begin poly = 16'h1021; w = 16; refl = 1'b0; end
            3: begin poly = 16'hA001; w = 16; refl = 1'b1; end
            default: begin poly = 16'h8005; w = 16; refl = 1'b0; end
        endcase
        if (refl) begin
            for (int i = 0; i < 8; i++) begin
                fb = c[0] ^ d[i];
                c  = c >> 1;
                if (fb) c = c ^ poly;
            end
        end else begin
            for (int i = 7; i >= 0; i--) begin
                fb = c[w-1] ^ d[i];
                c  = c << 1;
                if (w == 8) c[15:8] = 8'h00;
                if (fb) c = c ^ poly;
            end
        end
        return c;
    endfunction

    function automatic string tag_of(input int v);
        case (v)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string req);
        for (int k = 0; k < NV; k++) begin
            check(out_v[k] === mdl[k], {req, "/", tag_of(k)}, out_v[k], mdl[k]);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic cycle(input logic ini, input logic vld, input logic [7:0] b);
        init_i     = ini;
        byte_vld_i = vld;
        byte_i     = b;
        @(negedge clk);
        for (int k = 0; k < NV; k++) begin
            if (ini) mdl[k] = (k < 2) ? {8'h00, PRE[k][7:0]} : PRE[k];
            else if (vld) mdl[k] = serial_step(k, mdl[k], b);
        end
        init_i     = 1'b0;
        byte_vld_i = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        logic [15:0] snap;
        for (int k = 0; k < NV; k++) mdl[k] = (k < 2) ? {8'h00, PRE[k][7:0]} : PRE[k];
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset value
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // vector table walk: standard check string, then per-variant check value
        for (int i = 0; i < 9; i++) cycle(1'b0, 1'b1, MSG[i]);
        for (int k = 0; k < NV; k++) begin
            check(out_v[k] === CHECK[k], {"R11/", tag_of(k)}, out_v[k], CHECK[k]);
        end
        compare_all("R11");

        // R3 idle cycles keep the value even with a changing byte
        for (int i = 0; i < 3; i++) begin
            cycle(1'b0, 1'b0, 8'hA5 ^ 8'(i));
            compare_all("R3");
        end

        // R2 init wins over a valid byte
        cycle(1'b1, 1'b1, 8'h5A);
        compare_all("R2");

        // random streams with gaps and restarts
        for (int i = 0; i < 400; i++) begin
            int unsigned r = $urandom;
            cycle(r[7:0] == 8'h00, r[9:8] != 2'b00, 8'(r >> 16));
            compare_all("R11");
        end

        // R9 upper byte of the 8-bit variants
        check(out_v[0][15:8] === 8'h00, "R9", out_v[0], {8'h00, out_v[0][7:0]});
        check(out_v[1][15:8] === 8'h00, "R9", out_v[1], {8'h00, out_v[1][7:0]});

        // R4 bit 0 clear after an update from a preset-loaded state
        cycle(1'b0, 1'b1, 8'hFF);
        check(out_v[0][0] === 1'b0, "R4", out_v[0], mdl[0]);

        // R10 one-pass residue on the 0x1021 unit (preset all ones)
        cycle(1'b1, 1'b0, 8'h00);
        cycle(1'b0, 1'b1, 8'hDE);
        cycle(1'b0, 1'b1, 8'hAD);
        cycle(1'b0, 1'b1, 8'h01);
        snap = out_v[2];
        cycle(1'b0, 1'b1, snap[15:8]);
        cycle(1'b0, 1'b1, snap[7:0]);
        check(out_v[2] === 16'h0000, "R10", out_v[2], 16'h0000);
        compare_all("R10");

        done = 1'b1;
        summary();
    end
endmodule